// File: doc/BRIEF.md
# Bit-Band Alias Address Translator

This block sits between a bus master and the memory system and turns accesses to two bit-alias windows into accesses on single bits. One window covers the SRAM space and one covers the peripheral space. Every word in a 32MB alias window stands for one bit of the 1MB region at the bottom of the matching space.

A read through an alias word returns the chosen bit in bit 0. A write through an alias word becomes a locked read-modify-write of the underlying location. The underlying access keeps the size of the alias access. Any access outside both windows goes downstream untouched as one transaction.

The upstream side takes one request at a time on a valid/ready handshake and returns one response pulse. The downstream side issues valid/ready requests. Each downstream request is answered by an `mst_rvalid_i` pulse, for writes as well as reads.

Top module: `bitband_xlat`

## Requirements
- R1: An address outside both alias windows is forwarded as exactly one downstream transaction with the same address, size, direction and write data, and `mst_lock_o` low. A forwarded read returns the downstream read data unchanged.
- R2: An address whose bits [31:25] equal 7'h11 (0x2200_0000 to 0x23FF_FFFC) targets byte address 0x2000_0000 plus the alias offset shifted right by 5.
- R3: An address whose bits [31:25] equal 7'h21 (0x4200_0000 to 0x43FF_FFFC) targets byte address 0x4000_0000 plus the alias offset shifted right by 5.
- R4: The downstream size equals the request size, coded 0 byte, 1 halfword, 2 word. The alias target address has bits [1:0] cleared for a word and bit 0 cleared for a halfword.
- R5: An alias read issues one downstream read. It responds with data bit `offset[6:2]` in bit 0 and zero in bits [31:1]; this is the bit within the byte (offset[4:2]) plus eight times the byte lane.
- R6: An alias write issues a downstream read and then a downstream write to the same address and size. The written data equals the read data with only bit `offset[6:2]` replaced by bit 0 of the request write data.
- R7: `mst_lock_o` is high from the read request of an alias write until the response to its write. It is low for alias reads and forwarded accesses.
- R8: `req_ready_o` is high only while no request is in progress. Each accepted request produces exactly one single-cycle `rsp_valid_o` pulse. Write responses carry zero data.
- R9: While `rst_ni` is low, `mst_valid_o`, `mst_lock_o` and `rsp_valid_o` are low and `req_ready_o` is high. A reset during a transaction abandons it.
- R10: While `mst_valid_o` is high and `mst_ready_i` is low, address, size, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Upstream request valid |
| req_ready_o | output | 1 | Upstream request accepted this cycle |
| req_addr_i | input | 32 | Upstream byte address |
| req_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_we_i | input | 1 | Upstream write enable |
| req_wdata_i | input | 32 | Upstream write data |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_rdata_o | output | 32 | Response read data |
| mst_valid_o | output | 1 | Downstream request valid |
| mst_ready_i | input | 1 | Downstream request accepted |
| mst_addr_o | output | 32 | Downstream byte address |
| mst_size_o | output | 2 | Downstream access size |
| mst_we_o | output | 1 | Downstream write enable |
| mst_wdata_o | output | 32 | Downstream write data |
| mst_lock_o | output | 1 | Holds the memory for an atomic read-modify-write |
| mst_rvalid_i | input | 1 | Downstream response pulse |
| mst_rdata_i | input | 32 | Downstream read data |

## Verification
The translation is tried with alias reads and writes in both windows, at the first and last alias word and at offsets that select every byte lane. These patterns separate a wrong shift, a wrong region base and a wrong bit index. Byte, halfword and word sizes are mixed so that a lost size or a missing alignment shows up in the target address. Forwarded reads and writes are placed just below and just above the windows to expose off-by-one window decoding. Downstream stalls of several cycles and a reset in the middle of a read-modify-write show whether the request is held steady and whether the lock is dropped.

// File: rtl/bb_pkg.sv
`timescale 1ns/1ps
package bb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;
endpackage

// File: rtl/bb_win_dec.sv
`timescale 1ns/1ps
module bb_win_dec #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int ALIAS_W = 25,
  parameter int NWIN = 2,
  parameter logic [NWIN-1:0][AW-1:0] ALIAS_BASES = '0,
  parameter logic [NWIN-1:0][AW-1:0] REGION_BASES = '0
) (
  input  logic [AW-1:2]          addr_i,
  input  logic [1:0]             size_i,
  output logic                   hit_o,
  output logic [AW-1:0]          xaddr_o,
  output logic [$clog2(DW)-1:0]  bitpos_o
);
  import bb_pkg::*;
  localparam int BPW = $clog2(DW);
  localparam int RW  = ALIAS_W - BPW;

  logic [NWIN-1:0]         hit_vec;
  logic [NWIN-1:0][AW-1:0] tgt_vec;
  logic [AW-1:0]           tgt_sel;
  logic [AW-1:0]           align_mask;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign hit_vec[g] = (addr_i[AW-1:ALIAS_W] == ALIAS_BASES[g][AW-1:ALIAS_W]);
    assign tgt_vec[g] = REGION_BASES[g] | AW'(addr_i[ALIAS_W-1:BPW]);
  end

  always_comb begin
    hit_o   = 1'b0;
    tgt_sel = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (hit_vec[i]) begin
        hit_o   = 1'b1;
        tgt_sel = tgt_vec[i];
      end
    end
  end

  always_comb begin
    unique case (size_e'(size_i))
      SZ_BYTE: align_mask = '1;
      SZ_HALF: align_mask = ~AW'(1);
      default: align_mask = ~AW'(3);
    endcase
  end

  assign xaddr_o  = tgt_sel & align_mask;
  // bit in byte from offset[4:2], byte lane from the bits above
  assign bitpos_o = addr_i[BPW+1:2];

  // RW kept to document region width
  localparam int REGION_BYTES = 1 << RW;
endmodule

// File: rtl/bb_bit_ops.sv
`timescale 1ns/1ps
module bb_bit_ops #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]          rdata_i,
  input  logic [$clog2(DW)-1:0]  bitpos_i,
  input  logic                   wbit_i,
  output logic [DW-1:0]          rbit_word_o,
  output logic [DW-1:0]          merged_o
);
  always_comb begin
    rbit_word_o    = '0;
    rbit_word_o[0] = rdata_i[bitpos_i];
    merged_o           = rdata_i;
    merged_o[bitpos_i] = wbit_i;
  end
endmodule

// File: rtl/bb_seq.sv
`timescale 1ns/1ps
module bb_seq #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_size_i,
  input  logic          req_we_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  // decode side
  output logic [AW-1:0] addr_q_o,
  output logic [1:0]    size_q_o,
  input  logic          hit_i,
  input  logic [AW-1:0] xaddr_i,
  output logic [DW-1:0] rd_q_o,
  output logic          wbit_o,
  input  logic [DW-1:0] rbit_word_i,
  input  logic [DW-1:0] merged_i,
  // downstream
  output logic          mst_valid_o,
  input  logic          mst_ready_i,
  output logic [AW-1:0] mst_addr_o,
  output logic [1:0]    mst_size_o,
  output logic          mst_we_o,
  output logic [DW-1:0] mst_wdata_o,
  output logic          mst_lock_o,
  input  logic          mst_rvalid_i,
  input  logic [DW-1:0] mst_rdata_i
);
  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_WREQ, S_WWAIT, S_RESP} state_e;

  state_e        state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [1:0]    size_q;
  logic          we_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rd_q;
  logic          rmw;

  assign rmw = hit_i & we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      size_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && req_valid_i) begin
        addr_q  <= req_addr_i;
        size_q  <= req_size_i;
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
      end
      if (state_q == S_WAIT && mst_rvalid_i) rd_q <= mst_rdata_i;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (req_valid_i) state_d = S_REQ;
      S_REQ:   if (mst_ready_i) state_d = S_WAIT;
      S_WAIT:  if (mst_rvalid_i) state_d = rmw ? S_WREQ : S_RESP;
      S_WREQ:  if (mst_ready_i) state_d = S_WWAIT;
      S_WWAIT: if (mst_rvalid_i) state_d = S_RESP;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    mst_valid_o = 1'b0;
    mst_addr_o  = hit_i ? xaddr_i : addr_q;
    mst_size_o  = size_q;
    mst_we_o    = 1'b0;
    mst_wdata_o = wdata_q;
    mst_lock_o  = 1'b0;
    unique case (state_q)
      S_REQ: begin
        mst_valid_o = 1'b1;
        mst_we_o    = we_q & ~hit_i;
        mst_lock_o  = rmw;
      end
      S_WAIT:  mst_lock_o = rmw;
      S_WREQ: begin
        mst_valid_o = 1'b1;
        mst_we_o    = 1'b1;
        mst_wdata_o = merged_i;
        mst_lock_o  = 1'b1;
      end
      S_WWAIT: mst_lock_o = 1'b1;
      default: ;
    endcase
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign rsp_valid_o = (state_q == S_RESP);
  assign rsp_rdata_o = we_q ? '0 : (hit_i ? rbit_word_i : rd_q);
  assign addr_q_o    = addr_q;
  assign size_q_o    = size_q;
  assign rd_q_o      = rd_q;
  assign wbit_o      = wdata_q[0];

  // R10
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_valid_o && !mst_ready_i |=> mst_valid_o && $stable(mst_addr_o) && $stable(mst_we_o)
                                    && $stable(mst_wdata_o) && $stable(mst_size_o));
  // R7
  lock_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mst_lock_o) |-> $past(mst_rvalid_i));
  // R6
  lock_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mst_lock_o) |-> mst_valid_o && !mst_we_o);
  // R8
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);
  // R8
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mst_valid_o && !mst_lock_o && !rsp_valid_o);
  // R5
  alias_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && hit_i && !we_q |-> rsp_rdata_o[DW-1:1] == '0);
endmodule

// File: rtl/bitband_xlat.sv
`timescale 1ns/1ps
module bitband_xlat #(
  parameter int          AW         = 32,
  parameter int          DW         = 32,
  parameter int          ALIAS_W    = 25,
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter logic [31:0] SRAM_ALIAS = 32'h2200_0000,
  parameter logic [31:0] PERI_BASE  = 32'h4000_0000,
  parameter logic [31:0] PERI_ALIAS = 32'h4200_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_size_i,
  input  logic          req_we_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          mst_valid_o,
  input  logic          mst_ready_i,
  output logic [AW-1:0] mst_addr_o,
  output logic [1:0]    mst_size_o,
  output logic          mst_we_o,
  output logic [DW-1:0] mst_wdata_o,
  output logic          mst_lock_o,
  input  logic          mst_rvalid_i,
  input  logic [DW-1:0] mst_rdata_i
);
  localparam int BPW  = $clog2(DW);
  localparam int NWIN = 2;
  localparam logic [NWIN-1:0][AW-1:0] ALIAS_BASES  = {AW'(PERI_ALIAS), AW'(SRAM_ALIAS)};
  localparam logic [NWIN-1:0][AW-1:0] REGION_BASES = {AW'(PERI_BASE), AW'(SRAM_BASE)};

  logic [AW-1:0]  addr_q;
  logic [1:0]     size_q;
  logic           hit;
  logic [AW-1:0]  xaddr;
  logic [BPW-1:0] bitpos;
  logic [DW-1:0]  rd_q;
  logic           wbit;
  logic [DW-1:0]  rbit_word;
  logic [DW-1:0]  merged;

  bb_win_dec #(
    .AW(AW), .DW(DW), .ALIAS_W(ALIAS_W), .NWIN(NWIN),
    .ALIAS_BASES(ALIAS_BASES), .REGION_BASES(REGION_BASES)
  ) u_dec (
    .addr_i   (addr_q[AW-1:2]),
    .size_i   (size_q),
    .hit_o    (hit),
    .xaddr_o  (xaddr),
    .bitpos_o (bitpos)
  );

  bb_bit_ops #(.DW(DW)) u_bits (
    .rdata_i     (rd_q),
    .bitpos_i    (bitpos),
    .wbit_i      (wbit),
    .rbit_word_o (rbit_word),
    .merged_o    (merged)
  );

  bb_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_addr_i, .req_size_i, .req_we_i, .req_wdata_i,
    .rsp_valid_o, .rsp_rdata_o,
    .addr_q_o    (addr_q),
    .size_q_o    (size_q),
    .hit_i       (hit),
    .xaddr_i     (xaddr),
    .rd_q_o      (rd_q),
    .wbit_o      (wbit),
    .rbit_word_i (rbit_word),
    .merged_i    (merged),
    .mst_valid_o, .mst_ready_i, .mst_addr_o, .mst_size_o, .mst_we_o,
    .mst_wdata_o, .mst_lock_o, .mst_rvalid_i, .mst_rdata_i
  );
endmodule

// File: tb/sim_bitband_xlat.sv
`timescale 1ns/1ps
module sim_bitband_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_we = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mst_valid;
  logic        mst_ready = 1'b0;
  logic [31:0] mst_addr;
  logic [1:0]  mst_size;
  logic        mst_we;
  logic [31:0] mst_wdata;
  logic        mst_lock;
  logic        mst_rvalid = 1'b0;
  logic [31:0] mst_rdata = '0;

  always #2.5 clk = ~clk;

  bitband_xlat u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_we_i(req_we), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mst_valid_o(mst_valid), .mst_ready_i(mst_ready), .mst_addr_o(mst_addr),
    .mst_size_o(mst_size), .mst_we_o(mst_we), .mst_wdata_o(mst_wdata),
    .mst_lock_o(mst_lock), .mst_rvalid_i(mst_rvalid), .mst_rdata_i(mst_rdata)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_f(input logic [31:0] a);
    return 32'h5A3C_96E1 ^ {a[15:0], a[31:16]};
  endfunction

  // downstream slave model, driven away from the active edge
  logic [31:0] lg_addr [4];
  logic [1:0]  lg_size [4];
  logic        lg_we   [4];
  logic [31:0] lg_wdata[4];
  logic        lg_lock [4];
  int          n_log = 0;
  int          stall_cfg = 0;
  int          stall_cnt = 0;
  bit          rsp_pend = 0;
  bit          stalled = 0;
  logic [31:0] cur_addr, h_addr, h_wdata;
  logic        h_we;

  always @(negedge clk) begin
    mst_ready  = 1'b0;
    mst_rvalid = 1'b0;
    if (!rst_n) begin
      rsp_pend = 0;
      stalled  = 0;
    end else if (rsp_pend) begin
      mst_rvalid = 1'b1;
      mst_rdata  = mem_f(cur_addr);
      rsp_pend   = 0;
    end else if (mst_valid) begin
      if (stalled) begin
        chk("R10", "stalled addr", mst_addr, h_addr);
        chk("R10", "stalled wdata", mst_wdata, h_wdata);
        chk("R10", "stalled we", 32'(mst_we), 32'(h_we));
      end
      if (stall_cnt > 0) begin
        stall_cnt--;
        stalled = 1;
        h_addr  = mst_addr;
        h_wdata = mst_wdata;
        h_we    = mst_we;
      end else begin
        mst_ready = 1'b1;
        stalled   = 0;
        if (n_log < 4) begin
          lg_addr[n_log]  = mst_addr;
          lg_size[n_log]  = mst_size;
          lg_we[n_log]    = mst_we;
          lg_wdata[n_log] = mst_wdata;
          lg_lock[n_log]  = mst_lock;
        end
        n_log++;
        cur_addr  = mst_addr;
        rsp_pend  = 1;
        stall_cnt = stall_cfg;
      end
    end
  end

  localparam int NV = 10;
  localparam logic [31:0] V_ADDR [NV] = '{
    32'h2200_0000, 32'h2200_007C, 32'h23FF_FFFC, 32'h4200_0044, 32'h4210_0028,
    32'h2000_1234, 32'h4400_0010, 32'h21FF_FFFC, 32'h4300_0050, 32'h4200_0006};
  localparam logic [1:0] V_SIZE [NV] = '{2'd2, 2'd0, 2'd2, 2'd1, 2'd0, 2'd2, 2'd1, 2'd2, 2'd0, 2'd0};
  localparam bit V_WE [NV] = '{0, 0, 1, 1, 0, 0, 1, 0, 1, 1};
  localparam logic [31:0] V_WDATA [NV] = '{
    32'h0, 32'h0, 32'h0000_0001, 32'hFFFF_FFFE, 32'h0,
    32'h0, 32'hDEAD_BEEF, 32'h0, 32'hFFFF_FFFF, 32'h1234_5670};
  localparam int V_STALL [NV] = '{0, 1, 0, 2, 0, 3, 0, 1, 1, 0};

  task automatic issue(input logic [31:0] a, input logic [1:0] sz, input bit we,
                       input logic [31:0] wd, output bit got, output logic [31:0] rd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_we = we; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "ready while busy", 32'(req_ready), 32'd0);
    got = 0; rd = '0;
    for (int k = 0; k < 60 && !got; k++) begin
      if (rsp_valid) begin got = 1; rd = rsp_rdata; end
      else @(negedge clk);
    end
    chk("R8", "response seen", 32'(got), 32'd1);
    @(negedge clk);
    chk("R8", "response single cycle", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    bit          got;
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    chk("R9", "reset ready", 32'(req_ready), 32'd1);
    chk("R9", "reset mst_valid", 32'(mst_valid), 32'd0);
    chk("R9", "reset lock", 32'(mst_lock), 32'd0);
    chk("R9", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [31:0] a, base, tgt, m, expw;
      logic [24:0] off;
      logic [4:0]  bp;
      bit          is_alias;
      string       tag;
      a        = V_ADDR[v];
      is_alias = (a[31:25] == 7'h11) || (a[31:25] == 7'h21);
      tag      = !is_alias ? "R1" : (a[31:25] == 7'h11 ? "R2" : "R3");
      base     = (a[31:25] == 7'h11) ? 32'h2000_0000 : 32'h4000_0000;
      off      = a[24:0];
      tgt      = base + 32'(off >> 5);
      if (V_SIZE[v] == 2'd2) tgt[1:0] = 2'b00;
      if (V_SIZE[v] == 2'd1) tgt[0] = 1'b0;
      bp       = off[6:2];
      n_log     = 0;
      stall_cfg = V_STALL[v];
      stall_cnt = V_STALL[v];
      issue(a, V_SIZE[v], V_WE[v], V_WDATA[v], got, rd);
      if (!is_alias) begin
        chk("R1", "txn count", 32'(n_log), 32'd1);
        chk("R1", "fwd addr", lg_addr[0], a);
        chk("R4", "fwd size", 32'(lg_size[0]), 32'(V_SIZE[v]));
        chk("R1", "fwd we", 32'(lg_we[0]), 32'(V_WE[v]));
        chk("R7", "fwd lock", 32'(lg_lock[0]), 32'd0);
        if (V_WE[v]) begin
          chk("R1", "fwd wdata", lg_wdata[0], V_WDATA[v]);
          chk("R8", "write rsp data", rd, 32'd0);
        end else chk("R1", "fwd rdata", rd, mem_f(a));
      end else if (!V_WE[v]) begin
        chk("R5", "alias rd txn count", 32'(n_log), 32'd1);
        chk(tag, "alias rd addr", lg_addr[0], tgt);
        chk("R4", "alias rd size", 32'(lg_size[0]), 32'(V_SIZE[v]));
        chk("R7", "alias rd lock", 32'(lg_lock[0]), 32'd0);
        m = mem_f(tgt);
        chk("R5", "alias rd data", rd, 32'(m[bp]));
      end else begin
        m = mem_f(tgt);
        expw = m;
        expw[bp] = V_WDATA[v][0];
        chk("R6", "rmw txn count", 32'(n_log), 32'd2);
        chk(tag, "rmw read addr", lg_addr[0], tgt);
        chk("R6", "rmw read dir", 32'(lg_we[0]), 32'd0);
        chk("R6", "rmw write addr", lg_addr[1], tgt);
        chk("R6", "rmw write dir", 32'(lg_we[1]), 32'd1);
        chk("R4", "rmw sizes", {lg_size[0], lg_size[1]}, {V_SIZE[v], V_SIZE[v]});
        chk("R6", "rmw write data", lg_wdata[1], expw);
        chk("R7", "rmw lock", {lg_lock[0], lg_lock[1]}, 32'b11);
        chk("R8", "rmw rsp data", rd, 32'd0);
        @(negedge clk);
        chk("R7", "lock released", 32'(mst_lock), 32'd0);
      end
    end

    // reset in the middle of a locked read-modify-write
    n_log = 0; stall_cfg = 8; stall_cnt = 8;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h2200_0040; req_size = 2'd2; req_we = 1'b1; req_wdata = 32'h1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R7", "lock during rmw read", 32'(mst_lock), 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R9", "mid reset mst_valid", 32'(mst_valid), 32'd0);
    chk("R9", "mid reset lock", 32'(mst_lock), 32'd0);
    chk("R9", "mid reset ready", 32'(req_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    stall_cfg = 0; stall_cnt = 0; n_log = 0;
    repeat (4) @(negedge clk);
    chk("R9", "no txn after reset", 32'(n_log), 32'd0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #1ms;
    n_chk++;
    n_err++;
    $display("FAIL R8 watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule